// File: doc/BRIEF.md
# MMU Fault Syndrome Generator

This block sits beside an address-translation unit. When a translation attempt fails, the translation logic pulses a strobe and presents a result code, the kind of access (instruction fetch or data, read or write), the faulting address and the current MMU style. On that strobe the block works out which exception the core should take. It also computes the values for the core's fault-reporting registers: an error-code word, a fault-address register, a syndrome word, a TLB-miss register carrying a replacement-way hint, and a compare register holding the page-table-entry tag.

Three MMU styles are supported. The hashed page-table style raises the generic instruction-storage or data-storage exceptions. The plain software-TLB style raises dedicated TLB-miss exceptions and reports the address and a write flag. The way-hinted software-TLB style raises separate fetch, load and store miss exceptions, places a key bit in the error code, and suggests the next way to refill in round-robin order.

Any combination the block does not define raises an illegal flag and no exception. Every output is a register. A register changes only on a strobe, and holds its value until the next strobe or reset.

Top module: `mmu_fault_syndrome`

## Requirements
- R1: After reset every output is zero. Zero is the exception ID "none".
- R2: The outputs take their new values on the first rising clock edge at which `fault_stb` is high. While `fault_stb` is low, every output holds its value.
- R3: A fetch (`is_fetch`=1) with result code 0 ("no match") in style 0 (hashed table) gives exception ID 1 (instruction storage) and error code 0x40000000.
- R4: A fetch with result code 1 (rights violation) in style 0, 1 or 2 gives exception ID 1 and error code 0x08000000.
- R5: A fetch with result code 2 (no-execute) or code 3 (direct-store area) in style 0, 1 or 2 gives exception ID 1 and error code 0x10000000.
- R6: A data access with result code 0 in style 0 gives exception ID 2 (data storage) and error code 0. It loads the fault-address register with the address. It sets the syndrome to 0x42000000 for a write and to 0x40000000 for a read.
- R7: A result code 0 in style 1 (software TLB) gives error code 0, loads the fault-address register and sets the syndrome. A data access gives exception ID 4 (data TLB), with syndrome 0x00800000 for a write and 0 for a read. A fetch gives exception ID 3 (instruction TLB) with syndrome 0.
- R8: A result code 0 in style 2 (way-hinted TLB) gives exception ID 5 for a fetch, 6 for a data read and 7 for a data write. Its error code is zero except bit 19, which equals `key_bit`.
- R9: In that same case, the TLB-miss register takes the address with bits [1:0] cleared, ORed with (`last_way` + 1) modulo WAYS.
- R10: In that same case, the compare register takes `pte_tag` with its top bit forced to one.
- R11: These combinations set `illegal`, exception ID 0 and error code 0: style 3, a result code above 3, or a data access with a result code other than 0. Every other strobe clears `illegal`.
- R12: The fault-address and syndrome registers load only in the cases of R6 and R7. The TLB-miss and compare registers load only in the case of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_stb | input | 1 | Fault strobe; loads the outputs |
| res_code | input | 3 | Translation result: 0 no match, 1 rights, 2 no-execute, 3 direct-store |
| is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| is_write | input | 1 | 1 for a data write |
| mmu_style | input | 2 | 0 hashed table, 1 software TLB, 2 way-hinted TLB, 3 reserved |
| key_bit | input | 1 | Protection key bit for the way-hinted style |
| fault_addr | input | ADDR_W | Faulting address |
| pte_tag | input | ADDR_W | Page-table-entry tag for the compare register |
| last_way | input | WAY_W | Way used by the last refill |
| exc_id | output | 4 | Selected exception ID |
| err_code | output | 32 | Error-code word |
| fault_addr_reg | output | ADDR_W | Fault-address register |
| syndrome | output | 32 | Syndrome word |
| tlb_miss_reg | output | ADDR_W | TLB-miss register with way hint |
| tlb_cmp_reg | output | ADDR_W | Compare register |
| illegal | output | 1 | Undefined combination flag |

## Verification
Every result passes through exactly one register. All outputs are therefore due on the first rising edge after the strobe is sampled high. The reset itself takes two more edges to release, through the internal synchronizer. The bench raises the strobe at a falling edge for one cycle, drops it at the next falling edge, and samples there, half a cycle after the loading edge. Hold checks then change every input with the strobe low over several cycles and sample again at falling edges. The properties look exactly one cycle back, matching that latency.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned KEY_POS = 19;

  // result codes
  localparam logic [2:0] RC_MISS   = 3'd0;
  localparam logic [2:0] RC_RIGHTS = 3'd1;
  localparam logic [2:0] RC_NOEXEC = 3'd2;
  localparam logic [2:0] RC_DSTORE = 3'd3;

  // MMU styles
  localparam logic [1:0] ST_HASHED = 2'd0;
  localparam logic [1:0] ST_SOFT   = 2'd1;
  localparam logic [1:0] ST_WAY    = 2'd2;
  localparam logic [1:0] ST_RSVD   = 2'd3;

  typedef enum logic [3:0] {
    EXC_NONE      = 4'd0,
    EXC_INSN_STG  = 4'd1,
    EXC_DATA_STG  = 4'd2,
    EXC_INSN_TLB  = 4'd3,
    EXC_DATA_TLB  = 4'd4,
    EXC_FETCH_WAY = 4'd5,
    EXC_LOAD_WAY  = 4'd6,
    EXC_STORE_WAY = 4'd7
  } exc_e;

  localparam logic [WORD_W-1:0] ERR_NOMATCH = 32'h4000_0000;
  localparam logic [WORD_W-1:0] ERR_RIGHTS  = 32'h0800_0000;
  localparam logic [WORD_W-1:0] ERR_NOEXEC  = 32'h1000_0000;
  localparam logic [WORD_W-1:0] SYN_STG_RD  = 32'h4000_0000;
  localparam logic [WORD_W-1:0] SYN_STG_WR  = 32'h4200_0000;
  localparam logic [WORD_W-1:0] SYN_TLB_WR  = 32'h0080_0000;

  typedef struct packed {
    logic [3:0]        exc;
    logic [WORD_W-1:0] err;
    logic              bad;
    logic              ld_far;
    logic [WORD_W-1:0] syn;
    logic              ld_way;
  } dec_t;

endpackage

// File: rtl/mfs_decode.sv
module mfs_decode
  import mfs_pkg::*;
(
  input  logic [2:0] res_code,
  input  logic       is_fetch,
  input  logic       is_write,
  input  logic [1:0] mmu_style,
  input  logic       key_bit,
  output dec_t       dec
);

  logic code_ok;
  logic style_ok;

  assign code_ok  = (res_code <= RC_DSTORE);
  assign style_ok = (mmu_style != ST_RSVD);

  always_comb begin
    dec     = '0;
    dec.exc = EXC_NONE;
    if (!code_ok || !style_ok) begin
      dec.bad = 1'b1;
    end else if (is_fetch) begin
      unique case (res_code)
        RC_MISS: begin
          unique case (mmu_style)
            ST_HASHED: begin
              dec.exc = EXC_INSN_STG;
              dec.err = ERR_NOMATCH;
            end
            ST_SOFT: begin
              dec.exc    = EXC_INSN_TLB;
              dec.ld_far = 1'b1;
              dec.syn    = '0;
            end
            default: begin
              dec.exc          = EXC_FETCH_WAY;
              dec.err[KEY_POS] = key_bit;
              dec.ld_way       = 1'b1;
            end
          endcase
        end
        RC_RIGHTS: begin
          dec.exc = EXC_INSN_STG;
          dec.err = ERR_RIGHTS;
        end
        default: begin
          dec.exc = EXC_INSN_STG;
          dec.err = ERR_NOEXEC;
        end
      endcase
    end else if (res_code == RC_MISS) begin
      unique case (mmu_style)
        ST_HASHED: begin
          dec.exc    = EXC_DATA_STG;
          dec.ld_far = 1'b1;
          dec.syn    = is_write ? SYN_STG_WR : SYN_STG_RD;
        end
        ST_SOFT: begin
          dec.exc    = EXC_DATA_TLB;
          dec.ld_far = 1'b1;
          dec.syn    = is_write ? SYN_TLB_WR : '0;
        end
        default: begin
          dec.exc          = is_write ? EXC_STORE_WAY : EXC_LOAD_WAY;
          dec.err[KEY_POS] = key_bit;
          dec.ld_way       = 1'b1;
        end
      endcase
    end else begin
      dec.bad = 1'b1;
    end
  end

endmodule

// File: rtl/mfs_way_hint.sv
module mfs_way_hint #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tag,
  input  logic [WAY_W-1:0]  last_way,
  output logic [ADDR_W-1:0] miss_val,
  output logic [ADDR_W-1:0] cmp_val
);

  localparam logic [WAY_W-1:0]  WAY_MASK = WAY_W'(WAYS - 1);
  localparam logic [ADDR_W-1:0] TOP_BIT  = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [WAY_W-1:0] next_way;
  logic [WAY_W-1:0] hint;

  always_comb begin
    next_way = last_way + WAY_W'(1);
    hint     = next_way & WAY_MASK;
    miss_val = {addr[ADDR_W-1:2], 2'b00} | ADDR_W'(hint);
    cmp_val  = tag | TOP_BIT;
  end

endmodule

// File: rtl/mmu_fault_syndrome.sv
module mmu_fault_syndrome
  import mfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_stb,
  input  logic [2:0]        res_code,
  input  logic              is_fetch,
  input  logic              is_write,
  input  logic [1:0]        mmu_style,
  input  logic              key_bit,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ADDR_W-1:0] pte_tag,
  input  logic [WAY_W-1:0]  last_way,
  output logic [3:0]        exc_id,
  output logic [WORD_W-1:0] err_code,
  output logic [ADDR_W-1:0] fault_addr_reg,
  output logic [WORD_W-1:0] syndrome,
  output logic [ADDR_W-1:0] tlb_miss_reg,
  output logic [ADDR_W-1:0] tlb_cmp_reg,
  output logic              illegal
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  dec_t              dec;
  logic [ADDR_W-1:0] miss_val;
  logic [ADDR_W-1:0] cmp_val;

  mfs_decode u_decode (
    .res_code (res_code),
    .is_fetch (is_fetch),
    .is_write (is_write),
    .mmu_style(mmu_style),
    .key_bit  (key_bit),
    .dec      (dec)
  );

  mfs_way_hint #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_way_hint (
    .addr    (fault_addr),
    .tag     (pte_tag),
    .last_way(last_way),
    .miss_val(miss_val),
    .cmp_val (cmp_val)
  );

  // clock enables
  logic en_core;
  logic en_far;
  logic en_way;

  assign en_core = fault_stb;
  assign en_far  = fault_stb & dec.ld_far;
  assign en_way  = fault_stb & dec.ld_way;

  // next-state
  logic [3:0]        exc_d;
  logic [WORD_W-1:0] err_d;
  logic [ADDR_W-1:0] far_d;
  logic [WORD_W-1:0] syn_d;
  logic [ADDR_W-1:0] miss_d;
  logic [ADDR_W-1:0] cmp_d;
  logic              ill_d;

  always_comb begin
    exc_d  = exc_id;
    err_d  = err_code;
    ill_d  = illegal;
    far_d  = fault_addr_reg;
    syn_d  = syndrome;
    miss_d = tlb_miss_reg;
    cmp_d  = tlb_cmp_reg;
    if (en_core) begin
      exc_d = dec.exc;
      err_d = dec.err;
      ill_d = dec.bad;
    end
    if (en_far) begin
      far_d = fault_addr;
      syn_d = dec.syn;
    end
    if (en_way) begin
      miss_d = miss_val;
      cmp_d  = cmp_val;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      exc_id         <= '0;
      err_code       <= '0;
      illegal        <= 1'b0;
      fault_addr_reg <= '0;
      syndrome       <= '0;
      tlb_miss_reg   <= '0;
      tlb_cmp_reg    <= '0;
    end else begin
      exc_id         <= exc_d;
      err_code       <= err_d;
      illegal        <= ill_d;
      fault_addr_reg <= far_d;
      syndrome       <= syn_d;
      tlb_miss_reg   <= miss_d;
      tlb_cmp_reg    <= cmp_d;
    end
  end

endmodule

// File: rtl/mfs_chk.sv
module mfs_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              fault_stb,
  input logic [2:0]        res_code,
  input logic              is_fetch,
  input logic              is_write,
  input logic [1:0]        mmu_style,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [ADDR_W-1:0] pte_tag,
  input logic [WAY_W-1:0]  last_way,
  input logic [3:0]        exc_id,
  input logic [31:0]       err_code,
  input logic [ADDR_W-1:0] fault_addr_reg,
  input logic [31:0]       syndrome,
  input logic [ADDR_W-1:0] tlb_miss_reg,
  input logic [ADDR_W-1:0] tlb_cmp_reg,
  input logic              illegal
);

  logic way_miss;
  assign way_miss = fault_stb && mmu_style == 2'd2 && res_code == 3'd0;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fault_stb |=> $stable(exc_id) && $stable(err_code) && $stable(illegal)
      && $stable(fault_addr_reg) && $stable(syndrome)
      && $stable(tlb_miss_reg) && $stable(tlb_cmp_reg));

  p_fetch_rights_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_stb && is_fetch && res_code == 3'd1 && mmu_style != 2'd3
      |=> exc_id == 4'd1 && err_code == 32'h0800_0000);

  p_soft_store_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_stb && mmu_style == 2'd1 && !is_fetch && is_write && res_code == 3'd0
      |=> exc_id == 4'd4 && syndrome == 32'h0080_0000
        && fault_addr_reg == $past(fault_addr));

  p_way_hint_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    way_miss |=> tlb_miss_reg[ADDR_W-1:2] == $past(fault_addr[ADDR_W-1:2])
      && tlb_miss_reg[1:0] ==
         2'(($past(last_way) + WAY_W'(1)) & WAY_W'(WAYS - 1)));

  p_cmp_tag_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    way_miss |=> tlb_cmp_reg[ADDR_W-1]
      && tlb_cmp_reg[ADDR_W-2:0] == $past(pte_tag[ADDR_W-2:0]));

  p_rsvd_style_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_stb && mmu_style == 2'd3 |=> illegal && exc_id == 4'd0 && err_code == 32'd0);

  p_no_far_load_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_stb && mmu_style == 2'd2 |=> $stable(fault_addr_reg) && $stable(syndrome));

endmodule

bind mmu_fault_syndrome mfs_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) chk_i (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .fault_stb     (fault_stb),
  .res_code      (res_code),
  .is_fetch      (is_fetch),
  .is_write      (is_write),
  .mmu_style     (mmu_style),
  .fault_addr    (fault_addr),
  .pte_tag       (pte_tag),
  .last_way      (last_way),
  .exc_id        (exc_id),
  .err_code      (err_code),
  .fault_addr_reg(fault_addr_reg),
  .syndrome      (syndrome),
  .tlb_miss_reg  (tlb_miss_reg),
  .tlb_cmp_reg   (tlb_cmp_reg),
  .illegal       (illegal)
);

// File: tb/mmu_fault_syndrome_tb_top.sv
`timescale 1ns/1ps
module mmu_fault_syndrome_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_stb;
  logic [2:0]  res_code;
  logic        is_fetch;
  logic        is_write;
  logic [1:0]  mmu_style;
  logic        key_bit;
  logic [31:0] fault_addr;
  logic [31:0] pte_tag;
  logic [1:0]  last_way;
  logic [3:0]  exc_id;
  logic [31:0] err_code;
  logic [31:0] fault_addr_reg;
  logic [31:0] syndrome;
  logic [31:0] tlb_miss_reg;
  logic [31:0] tlb_cmp_reg;
  logic        illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mmu_fault_syndrome #(.ADDR_W(32), .WAYS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_stb(fault_stb), .res_code(res_code),
    .is_fetch(is_fetch), .is_write(is_write), .mmu_style(mmu_style),
    .key_bit(key_bit), .fault_addr(fault_addr), .pte_tag(pte_tag),
    .last_way(last_way), .exc_id(exc_id), .err_code(err_code),
    .fault_addr_reg(fault_addr_reg), .syndrome(syndrome),
    .tlb_miss_reg(tlb_miss_reg), .tlb_cmp_reg(tlb_cmp_reg), .illegal(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] rc, input logic f, input logic w,
                      input logic [1:0] st, input logic k,
                      input logic [31:0] a, input logic [31:0] t,
                      input logic [1:0] lw);
    @(negedge clk);
    res_code = rc; is_fetch = f; is_write = w; mmu_style = st;
    key_bit = k; fault_addr = a; pte_tag = t; last_way = lw;
    fault_stb = 1'b1;
    @(negedge clk);
    fault_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "exc_id", 32'(exc_id), 32'd0);
    chk("R1", "err_code", err_code, 32'd0);
    chk("R1", "fault_addr_reg", fault_addr_reg, 32'd0);
    chk("R1", "syndrome", syndrome, 32'd0);
    chk("R1", "tlb_miss_reg", tlb_miss_reg, 32'd0);
    chk("R1", "tlb_cmp_reg", tlb_cmp_reg, 32'd0);
    chk("R1", "illegal", 32'(illegal), 32'd0);
  endtask

  task automatic t_fetch_hashed;
    fire(3'd0, 1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_1000, 32'h0, 2'd0);
    chk("R3", "exc_id", 32'(exc_id), 32'd1);
    chk("R3", "err_code", err_code, 32'h4000_0000);
    chk("R12", "far untouched", fault_addr_reg, 32'd0);
  endtask

  task automatic t_fetch_prot;
    fire(3'd1, 1'b1, 1'b0, 2'd2, 1'b1, 32'h2000_0000, 32'h0, 2'd0);
    chk("R4", "exc_id", 32'(exc_id), 32'd1);
    chk("R4", "err_code", err_code, 32'h0800_0000);
    fire(3'd2, 1'b1, 1'b0, 2'd1, 1'b0, 32'h2000_0004, 32'h0, 2'd0);
    chk("R5", "noexec err", err_code, 32'h1000_0000);
    fire(3'd3, 1'b1, 1'b0, 2'd0, 1'b0, 32'h2000_0008, 32'h0, 2'd0);
    chk("R5", "dstore exc", 32'(exc_id), 32'd1);
    chk("R5", "dstore err", err_code, 32'h1000_0000);
  endtask

  task automatic t_data_hashed;
    fire(3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'hCAFE_0010, 32'h0, 2'd0);
    chk("R6", "exc_id", 32'(exc_id), 32'd2);
    chk("R6", "err_code", err_code, 32'd0);
    chk("R6", "far", fault_addr_reg, 32'hCAFE_0010);
    chk("R6", "syn write", syndrome, 32'h4200_0000);
    fire(3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'hCAFE_0020, 32'h0, 2'd0);
    chk("R6", "syn read", syndrome, 32'h4000_0000);
    chk("R6", "far read", fault_addr_reg, 32'hCAFE_0020);
  endtask

  task automatic t_soft;
    fire(3'd0, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0BAD_F00C, 32'h0, 2'd0);
    chk("R7", "exc_id store", 32'(exc_id), 32'd4);
    chk("R7", "syn store", syndrome, 32'h0080_0000);
    chk("R7", "far store", fault_addr_reg, 32'h0BAD_F00C);
    chk("R7", "err", err_code, 32'd0);
    fire(3'd0, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0BAD_F010, 32'h0, 2'd0);
    chk("R7", "syn load", syndrome, 32'd0);
    fire(3'd0, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0BAD_F020, 32'h0, 2'd0);
    chk("R7", "exc_id fetch", 32'(exc_id), 32'd3);
    chk("R7", "far fetch", fault_addr_reg, 32'h0BAD_F020);
    chk("R7", "syn fetch", syndrome, 32'd0);
    chk("R12", "miss reg untouched", tlb_miss_reg, 32'd0);
  endtask

  task automatic t_way;
    logic [31:0] exp_miss;
    fire(3'd0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h1234_5677, 32'h0000_0ABC, 2'd3);
    exp_miss = (32'h1234_5677 & ~32'h3) | 32'((2'd3 + 2'd1) & 2'd3);
    chk("R8", "exc store", 32'(exc_id), 32'd7);
    chk("R8", "err key", err_code, 32'h0008_0000);
    chk("R9", "miss wrap", tlb_miss_reg, exp_miss);
    chk("R10", "cmp", tlb_cmp_reg, 32'h8000_0ABC);
    chk("R12", "far kept", fault_addr_reg, 32'h0BAD_F020);
    fire(3'd0, 1'b0, 1'b0, 2'd2, 1'b0, 32'h1234_5677, 32'h8000_0001, 2'd1);
    exp_miss = (32'h1234_5677 & ~32'h3) | 32'((2'd1 + 2'd1) & 2'd3);
    chk("R8", "exc load", 32'(exc_id), 32'd6);
    chk("R8", "err no key", err_code, 32'd0);
    chk("R9", "miss hint", tlb_miss_reg, exp_miss);
    chk("R10", "cmp set top", tlb_cmp_reg, 32'h8000_0001);
    fire(3'd0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0000_4001, 32'h0000_0005, 2'd0);
    chk("R8", "exc fetch", 32'(exc_id), 32'd5);
    chk("R9", "miss fetch", tlb_miss_reg, 32'h0000_4001);
    chk("R12", "syn kept", syndrome, 32'd0);
  endtask

  task automatic t_illegal;
    fire(3'd0, 1'b0, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF, 32'h1, 2'd0);
    chk("R11", "illegal style", 32'(illegal), 32'd1);
    chk("R11", "exc none", 32'(exc_id), 32'd0);
    chk("R11", "err zero", err_code, 32'd0);
    chk("R12", "miss kept", tlb_miss_reg, 32'h0000_4001);
    fire(3'd5, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 2'd0);
    chk("R11", "illegal code", 32'(illegal), 32'd1);
    fire(3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 2'd0);
    chk("R11", "illegal data rights", 32'(illegal), 32'd1);
    chk("R11", "exc none data", 32'(exc_id), 32'd0);
    fire(3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 2'd0);
    chk("R11", "illegal cleared", 32'(illegal), 32'd0);
  endtask

  task automatic t_hold;
    fire(3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h5555_AAA0, 32'h0, 2'd0);
    chk("R2", "loaded next edge", fault_addr_reg, 32'h5555_AAA0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      res_code = 3'(i); is_fetch = i[0]; mmu_style = 2'(i);
      fault_addr = 32'h1111_0000 + 32'(i); pte_tag = 32'(i); last_way = 2'(i);
    end
    @(negedge clk);
    chk("R2", "exc hold", 32'(exc_id), 32'd2);
    chk("R2", "far hold", fault_addr_reg, 32'h5555_AAA0);
    chk("R2", "syn hold", syndrome, 32'h4200_0000);
    chk("R2", "miss hold", tlb_miss_reg, 32'h0000_4001);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fault_stb = 1'b0; res_code = '0; is_fetch = 1'b0;
    is_write = 1'b0; mmu_style = '0; key_bit = 1'b0; fault_addr = '0;
    pte_tag = '0; last_way = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fetch_hashed();
    t_fetch_prot();
    t_data_hashed();
    t_soft();
    t_way();
    t_illegal();
    t_hold();
    finish_run();
  end

endmodule